// File: doc/BRIEF.md
# Chunked DDC Read Controller

This block runs byte-level read transactions on a display data channel on behalf of host software. Software programs a transfer length and an access type into a control register and sets the enable bit. The controller then pulls bytes one at a time from an abstract byte engine and stores them in a 64-byte read window. Software drains the window as sixteen 32-bit words.

When the window fills and bytes are still outstanding, the controller raises a buffer-full event and stops requesting bytes. It waits until software sets the continue bit, then clears the window and fetches the next chunk. The last chunk, which may be partial, raises a completion event instead. An error from the byte engine aborts the transfer. Completion, buffer-full, error and a hot-plug edge are each latched in a write-one-to-clear status register. An enable register masks them onto a single registered interrupt line.

Top module: `ddc_chunk_reader`

## Requirements
- R1: After reset, the control, interrupt-enable and status registers read zero, `irq` and `eng_req` are low, and every window word reads zero.
- R2: A control write at word address 0x00 with bit 0 set, made while the block is idle, starts a transfer. The write latches the type from bits 3:2 and the byte count from bits 31:20, and `eng_req` goes high. `eng_type` shows the type. `eng_rd` is high for types 1, 2 and 3 and low for type 0.
- R3: The window sits at word addresses 0x10 to 0x1F. Byte n of the current chunk is in word n/4, lane n%4, with lane 0 in bits 7:0.
- R4: When the 64th byte of a chunk arrives and more bytes remain, status bit 3 (buffer full) is set and `eng_req` stays low. Writing control bit 1 (continue) with bit 0 still set clears the window and resumes fetching.
- R5: The continue bit reads back as zero once the fetch has restarted. Writing continue before clearing buffer-full still resumes the transfer.
- R6: When the last requested byte arrives, status bit 2 (done) is set and `eng_req` drops. The final chunk never sets buffer-full, even when it is exactly 64 bytes. Window bytes past the end of the data read zero. A transfer of length 0 completes with no byte request.
- R7: `eng_err` during a request stops the transfer and sets status bit 4. Done is not set, and the window keeps the bytes stored before the failure.
- R8: Writing the status register (word address 0x02) clears every bit written as one. Bits written as zero are unchanged.
- R9: `irq` is a register that follows, one cycle later, the OR of the status bits ANDed with the matching bits of the enable register (word address 0x01, same layout). With the enable clear, `irq` stays low.
- R10: While enabled, a control write changes only bits 0 and 1. The type and length fields keep their latched values.
- R11: A rising edge on `hpd_in` sets status bit 0.
- R12: A control write with bit 0 clear during a transfer stops byte requests and does not set done.
- R13: In a type 0 transfer, the byte handshakes are counted but no data is stored, so the window reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_wr_en | input | 1 | Host write strobe |
| hb_addr | input | 6 | Host word address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data for `hb_addr` (combinational) |
| eng_req | output | 1 | Byte request to the byte engine |
| eng_rd | output | 1 | High when the access type reads |
| eng_type | output | 2 | Access type of the running transfer |
| eng_byte | input | 8 | Byte returned by the engine |
| eng_valid | input | 1 | `eng_byte` holds a completed byte |
| eng_err | input | 1 | NACK or bus error from the engine |
| hpd_in | input | 1 | Hot-plug status |
| irq | output | 1 | Registered interrupt |

## Verification
A wrong chunk position or byte count shows up in the window as bytes shifted into the wrong lane or word. It also shows up as a buffer-full event one chunk early or late, or as a done event that arrives without the expected number of full events. All of these are visible within one chunk of the fault. A stuck continue request or a mis-ordered event shows up as `eng_req` rising without a host action, or never rising again, within a cycle. A mask or clear fault shows up on `irq` one cycle after the status change.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_PAUSE = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAIL  = 3'd4
    } xfer_state_e;

    typedef enum logic [1:0] {
        XT_SEC_WRITE = 2'd0,
        XT_SEC_LINK  = 2'd1,
        XT_SEC_READ  = 2'd2,
        XT_MON_READ  = 2'd3
    } xfer_type_e;

    typedef struct packed {
        logic err;
        logic full;
        logic done;
    } xfer_evt_t;

    // control register fields
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_CONT_BIT = 1;
    localparam int CTL_TYPE_LSB = 2;
    localparam int CTL_LEN_LSB  = 20;

    // interrupt bit positions
    localparam int IRQ_W    = 5;
    localparam int IRQ_HPD  = 0;
    localparam int IRQ_DONE = 2;
    localparam int IRQ_FULL = 3;
    localparam int IRQ_ERR  = 4;
    localparam logic [IRQ_W-1:0] IRQ_MASK = 5'b11101;

    // word addresses
    localparam int A_CTRL = 0;
    localparam int A_IEN  = 1;
    localparam int A_STS  = 2;

    function automatic logic type_reads(input xfer_type_e t);
        return t != XT_SEC_WRITE;
    endfunction

endpackage

// File: rtl/ddc_read_window.sv
module ddc_read_window #(
    parameter int WIN_WORDS = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clr_i,
    input  logic                              wr_en_i,
    input  logic [$clog2(WIN_WORDS*4)-1:0]    wr_pos_i,
    input  logic [7:0]                        wr_byte_i,
    input  logic [$clog2(WIN_WORDS)-1:0]      rd_idx_i,
    output logic [31:0]                       rd_word_o
);
    localparam int WIN_BYTES = WIN_WORDS * 4;
    localparam int POS_W     = $clog2(WIN_BYTES);

    logic [WIN_BYTES-1:0][7:0] bytes_all;

    generate
        for (genvar i = 0; i < WIN_BYTES; i++) begin : g_byte
            logic [7:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst || clr_i) begin
                    cell_q <= '0;
                end else if (wr_en_i && (wr_pos_i == POS_W'(i))) begin
                    cell_q <= wr_byte_i;
                end
            end
            assign bytes_all[i] = cell_q;
        end
    endgenerate

    assign rd_word_o = bytes_all[{rd_idx_i, 2'b00} +: 4];

endmodule

// File: rtl/ddc_xfer_seq.sv
module ddc_xfer_seq
    import ddc_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int WIN_BYTES = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic                         abort_i,
    input  logic [LEN_W-1:0]             new_len_i,
    input  logic [LEN_W-1:0]             len_i,
    input  logic                         cont_req_i,
    input  logic                         eng_valid_i,
    input  logic                         eng_err_i,
    output logic                         eng_req_o,
    output logic                         win_clr_o,
    output logic                         win_wr_o,
    output logic [$clog2(WIN_BYTES)-1:0] win_pos_o,
    output xfer_evt_t                    evt_o,
    output logic                         cont_take_o
);
    localparam int POS_W = $clog2(WIN_BYTES);

    xfer_state_e       state_q, state_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d;
    logic [POS_W-1:0]  pos_q, pos_d;
    logic              take, last, win_end, fetching;

    always_comb begin
        fetching    = (state_q == ST_FETCH);
        take        = fetching && eng_valid_i && !eng_err_i && !abort_i;
        last        = (cnt_q + LEN_W'(1)) == len_i;
        win_end     = (pos_q == POS_W'(WIN_BYTES - 1));

        eng_req_o   = fetching;
        evt_o.err   = fetching && eng_err_i && !abort_i;
        evt_o.done  = (take && last) ||
                      ((state_q == ST_IDLE) && start_i && (new_len_i == '0));
        evt_o.full  = take && !last && win_end;
        cont_take_o = (state_q == ST_PAUSE) && cont_req_i && !abort_i;
        win_clr_o   = ((state_q == ST_IDLE) && start_i) || cont_take_o;
        win_wr_o    = take;
        win_pos_o   = pos_q;

        state_d = state_q;
        cnt_d   = cnt_q;
        pos_d   = pos_q;
        if (abort_i) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cnt_d   = '0;
                        pos_d   = '0;
                        state_d = (new_len_i == '0) ? ST_DONE : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (eng_err_i) begin
                        state_d = ST_FAIL;
                    end else if (take) begin
                        cnt_d = cnt_q + LEN_W'(1);
                        pos_d = pos_q + POS_W'(1);
                        if (last) begin
                            state_d = ST_DONE;
                        end else if (win_end) begin
                            state_d = ST_PAUSE;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (cont_take_o) begin
                        pos_d   = '0;
                        state_d = ST_FETCH;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pos_q   <= pos_d;
        end
    end

endmodule

// File: rtl/ddc_irq_ctrl.sv
module ddc_irq_ctrl
    import ddc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] set_i,
    input  logic             ien_we_i,
    input  logic             sts_we_i,
    input  logic [IRQ_W-1:0] wdata_i,
    output logic [IRQ_W-1:0] ien_o,
    output logic [IRQ_W-1:0] sts_o,
    output logic             irq_o
);
    logic [IRQ_W-1:0] clr_vec;

    always_comb begin
        clr_vec = sts_we_i ? wdata_i : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_o <= '0;
            sts_o <= '0;
            irq_o <= 1'b0;
        end else begin
            if (ien_we_i) begin
                ien_o <= wdata_i & IRQ_MASK;
            end
            sts_o <= ((sts_o & ~clr_vec) | set_i) & IRQ_MASK;
            irq_o <= |(sts_o & ien_o);
        end
    end

endmodule

// File: rtl/ddc_chunk_reader.sv
module ddc_chunk_reader
    import ddc_pkg::*;
#(
    parameter int LEN_W     = 12,
    parameter int WIN_WORDS = 16,
    parameter int ADDR_W    = 6,
    parameter int WIN_BASE  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hb_wr_en,
    input  logic [ADDR_W-1:0] hb_addr,
    input  logic [31:0]       hb_wdata,
    output logic [31:0]       hb_rdata,
    output logic              eng_req,
    output logic              eng_rd,
    output logic [1:0]        eng_type,
    input  logic [7:0]        eng_byte,
    input  logic              eng_valid,
    input  logic              eng_err,
    input  logic              hpd_in,
    output logic              irq
);
    localparam int WIN_BYTES = WIN_WORDS * 4;
    localparam int POS_W     = $clog2(WIN_BYTES);
    localparam int IDX_W     = $clog2(WIN_WORDS);

    logic             en_q, cont_q, hpd_q;
    xfer_type_e       type_q;
    logic [LEN_W-1:0] len_q, new_len;
    logic             ctrl_we, ien_we, sts_we, start, abort;
    logic             cont_take, win_clr, win_wr;
    logic [POS_W-1:0] win_pos;
    xfer_evt_t        evt;
    logic [IRQ_W-1:0] set_vec, ien_q, sts_q;
    logic             win_hit;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      win_word;

    // host write decode
    always_comb begin
        ctrl_we = hb_wr_en && (hb_addr == ADDR_W'(A_CTRL));
        ien_we  = hb_wr_en && (hb_addr == ADDR_W'(A_IEN));
        sts_we  = hb_wr_en && (hb_addr == ADDR_W'(A_STS));
        start   = ctrl_we && hb_wdata[CTL_EN_BIT] && !en_q;
        abort   = ctrl_we && !hb_wdata[CTL_EN_BIT] && en_q;
        new_len = hb_wdata[CTL_LEN_LSB +: LEN_W];
    end

    // control register: fields locked while enabled
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cont_q <= 1'b0;
            type_q <= XT_SEC_WRITE;
            len_q  <= '0;
        end else begin
            if (ctrl_we) begin
                en_q <= hb_wdata[CTL_EN_BIT];
                if (!en_q) begin
                    type_q <= xfer_type_e'(hb_wdata[CTL_TYPE_LSB +: 2]);
                    len_q  <= new_len;
                end
            end
            if (ctrl_we && !hb_wdata[CTL_EN_BIT]) begin
                cont_q <= 1'b0;
            end else if (cont_take) begin
                cont_q <= 1'b0;
            end else if (ctrl_we && hb_wdata[CTL_CONT_BIT] && en_q) begin
                cont_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hpd_q <= 1'b0;
        end else begin
            hpd_q <= hpd_in;
        end
    end

    ddc_xfer_seq #(
        .LEN_W     (LEN_W),
        .WIN_BYTES (WIN_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .abort_i     (abort),
        .new_len_i   (new_len),
        .len_i       (len_q),
        .cont_req_i  (cont_q),
        .eng_valid_i (eng_valid),
        .eng_err_i   (eng_err),
        .eng_req_o   (eng_req),
        .win_clr_o   (win_clr),
        .win_wr_o    (win_wr),
        .win_pos_o   (win_pos),
        .evt_o       (evt),
        .cont_take_o (cont_take)
    );

    ddc_read_window #(
        .WIN_WORDS (WIN_WORDS)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (win_clr),
        .wr_en_i   (win_wr && type_reads(type_q)),
        .wr_pos_i  (win_pos),
        .wr_byte_i (eng_byte),
        .rd_idx_i  (rd_idx),
        .rd_word_o (win_word)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[IRQ_HPD]  = hpd_in && !hpd_q;
        set_vec[IRQ_DONE] = evt.done;
        set_vec[IRQ_FULL] = evt.full;
        set_vec[IRQ_ERR]  = evt.err;
    end

    ddc_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_vec),
        .ien_we_i (ien_we),
        .sts_we_i (sts_we),
        .wdata_i  (hb_wdata[IRQ_W-1:0]),
        .ien_o    (ien_q),
        .sts_o    (sts_q),
        .irq_o    (irq)
    );

    assign eng_rd   = type_reads(type_q);
    assign eng_type = type_q;

    // host read mux
    always_comb begin
        win_hit  = (hb_addr >= ADDR_W'(WIN_BASE)) &&
                   (hb_addr <  ADDR_W'(WIN_BASE + WIN_WORDS));
        rd_idx   = IDX_W'(hb_addr - ADDR_W'(WIN_BASE));
        hb_rdata = '0;
        if (hb_addr == ADDR_W'(A_CTRL)) begin
            hb_rdata[CTL_EN_BIT]             = en_q;
            hb_rdata[CTL_CONT_BIT]           = cont_q;
            hb_rdata[CTL_TYPE_LSB +: 2]      = type_q;
            hb_rdata[CTL_LEN_LSB +: LEN_W]   = len_q;
        end else if (hb_addr == ADDR_W'(A_IEN)) begin
            hb_rdata[IRQ_W-1:0] = ien_q;
        end else if (hb_addr == ADDR_W'(A_STS)) begin
            hb_rdata[IRQ_W-1:0] = sts_q;
        end else if (win_hit) begin
            hb_rdata = win_word;
        end
    end

endmodule

// File: rtl/ddc_chunk_reader_chk.sv
module ddc_chunk_reader_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             eng_req,
    input logic             eng_err,
    input logic             irq,
    input logic             en_q,
    input logic             cont_q,
    input logic [LEN_W-1:0] len_q,
    input logic [1:0]       type_q,
    input logic [4:0]       sts_q,
    input logic [4:0]       ien_q,
    input logic [2:0]       evt,
    input logic             cont_take,
    input logic             abort
);
    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|(sts_q & ien_q)));

    // R12
    req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !eng_req);

    // R10
    field_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && $past(en_q)) |-> ($stable(len_q) && $stable(type_q)));

    // R6
    done_latch_chk: assert property (@(posedge clk) disable iff (rst)
        evt[0] |=> sts_q[2]);

    // R4
    full_pause_chk: assert property (@(posedge clk) disable iff (rst)
        evt[1] |=> (!eng_req && sts_q[3]));

    // R7
    err_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && eng_err && !abort) |=> (sts_q[4] && !eng_req));

    // R5
    cont_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cont_take |=> !cont_q);

    // R6
    evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt));

endmodule

bind ddc_chunk_reader ddc_chunk_reader_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .eng_req   (eng_req),
    .eng_err   (eng_err),
    .irq       (irq),
    .en_q      (en_q),
    .cont_q    (cont_q),
    .len_q     (len_q),
    .type_q    (type_q),
    .sts_q     (sts_q),
    .ien_q     (ien_q),
    .evt       (evt),
    .cont_take (cont_take),
    .abort     (abort)
);

// File: tb/ddc_chunk_reader_tb.sv
module ddc_chunk_reader_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hb_wr_en = 1'b0;
    logic [5:0]  hb_addr = '0;
    logic [31:0] hb_wdata = '0;
    logic [31:0] hb_rdata;
    logic        eng_req, eng_rd;
    logic [1:0]  eng_type;
    logic [7:0]  eng_byte = '0;
    logic        eng_valid = 1'b0;
    logic        eng_err = 1'b0;
    logic        hpd_in = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int eng_idx = 0;
    int eng_gap = 0;
    int eng_err_at = -1;
    bit req_seen = 0;

    localparam logic [5:0] A_CTRL = 6'h00, A_IEN = 6'h01, A_STS = 6'h02, A_WIN = 6'h10;

    // {type[1:0], len[11:0], gap[3:0], cont_first}
    localparam int NVEC = 6;
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd3, 12'd10,  4'd0, 1'b0},
        {2'd3, 12'd64,  4'd1, 1'b0},
        {2'd3, 12'd130, 4'd0, 1'b0},
        {2'd2, 12'd65,  4'd2, 1'b0},
        {2'd0, 12'd5,   4'd0, 1'b0},
        {2'd1, 12'd100, 4'd0, 1'b1}
    };

    always #10 clk = ~clk;

    ddc_chunk_reader u_dut (
        .clk       (clk),
        .rst       (rst),
        .hb_wr_en  (hb_wr_en),
        .hb_addr   (hb_addr),
        .hb_wdata  (hb_wdata),
        .hb_rdata  (hb_rdata),
        .eng_req   (eng_req),
        .eng_rd    (eng_rd),
        .eng_type  (eng_type),
        .eng_byte  (eng_byte),
        .eng_valid (eng_valid),
        .eng_err   (eng_err),
        .hpd_in    (hpd_in),
        .irq       (irq)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 5) ^ (i >> 2));
    endfunction

    // byte engine model
    initial begin
        int gap_cnt;
        gap_cnt = 0;
        forever begin
            @(negedge clk);
            eng_valid = 1'b0;
            eng_err   = 1'b0;
            if (eng_req) begin
                req_seen = 1;
                if (gap_cnt < eng_gap) begin
                    gap_cnt++;
                end else begin
                    gap_cnt = 0;
                    if (eng_idx == eng_err_at) begin
                        eng_err = 1'b1;
                    end else begin
                        eng_valid = 1'b1;
                        eng_byte  = pat(eng_idx);
                    end
                    eng_idx++;
                end
            end else begin
                gap_cnt = 0;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        hb_addr  = a;
        hb_wdata = d;
        hb_wr_en = 1'b1;
        @(negedge clk);
        hb_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        hb_addr = a;
        #1;
        d = hb_rdata;
    endtask

    task automatic wait_irq(input int max, output bit ok);
        ok = 0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (irq) begin
                ok = 1;
                break;
            end
        end
    endtask

    // R3: byte k of the chunk in word k/4, lane k%4
    task automatic check_win(input string tag, input int base, input int nvalid, input bit stored);
        logic [31:0] d;
        int mism;
        logic [7:0] exp;
        mism = 0;
        for (int w = 0; w < 16; w++) begin
            bus_rd(A_WIN + 6'(w), d);
            for (int b = 0; b < 4; b++) begin
                exp = (stored && (4 * w + b) < nvalid) ? pat(base + 4 * w + b) : 8'h00;
                if (d[8 * b +: 8] !== exp) mism++;
            end
        end
        check(tag, mism, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic run_xfer(input logic [1:0] typ, input int len, input int gap, input bit cont_first);
        logic [31:0] s, c;
        int nfull, base;
        bit ok, fin;
        eng_idx = 0;
        eng_gap = gap;
        eng_err_at = -1;
        bus_wr(A_CTRL, (32'(len) << 20) | (32'(typ) << 2) | 32'h1);
        // R2
        check("R2 start request/type", {29'b0, eng_req, eng_rd, 1'b0} | 32'(eng_type) << 4,
              {29'b0, 1'b1, (typ != 2'd0), 1'b0} | 32'(typ) << 4);
        nfull = 0;
        base = 0;
        fin = 0;
        while (!fin) begin
            wait_irq(3000, ok);
            if (!ok) begin
                check("R6 transfer completes", 0, 1);
                break;
            end
            bus_rd(A_STS, s);
            if (s[3]) begin
                // R4
                check_win("R4 full chunk data", base, 64, typ != 2'd0);
                check("R4 paused", {31'b0, eng_req}, 0);
                nfull++;
                if (cont_first) begin
                    bus_wr(A_CTRL, 32'h3);
                    bus_wr(A_STS, 32'h8);
                    bus_rd(A_CTRL, c);
                    check("R5 continue self-clears", {31'b0, c[1]}, 0);
                end else begin
                    bus_wr(A_STS, 32'h8);
                    bus_wr(A_CTRL, 32'h3);
                end
                base += 64;
                repeat (2) @(negedge clk);
            end else if (s[2]) begin
                // R6, R13
                check_win(typ == 2'd0 ? "R13 write type stores nothing" : "R6 final chunk data",
                          base, len - base, typ != 2'd0);
                check("R6 no request after done", {31'b0, eng_req}, 0);
                fin = 1;
            end else begin
                check("R6 unexpected status", s, 32'h4);
                fin = 1;
            end
        end
        check("R6 full events before done", nfull, (len - 1) / 64);
        bus_wr(A_STS, 32'h1c);
        bus_wr(A_CTRL, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] d, s;
        bit ok;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1
        bus_rd(A_CTRL, d); check("R1 ctrl reset", d, 0);
        bus_rd(A_IEN, d);  check("R1 ien reset", d, 0);
        bus_rd(A_STS, d);  check("R1 status reset", d, 0);
        check("R1 irq/req reset", {30'b0, irq, eng_req}, 0);
        check_win("R1 window reset", 0, 0, 1);

        bus_wr(A_IEN, 32'h1d);

        for (int v = 0; v < NVEC; v++) begin
            run_xfer(VEC[v][18:17], int'(VEC[v][16:5]), int'(VEC[v][4:1]), VEC[v][0]);
        end

        // R6: length zero
        req_seen = 0;
        bus_wr(A_CTRL, (32'd0 << 20) | (32'd3 << 2) | 32'h1);
        repeat (4) @(negedge clk);
        bus_rd(A_STS, s);
        check("R6 zero length done", s & 32'h1c, 32'h4);
        check("R6 zero length no request", {31'b0, req_seen}, 0);
        bus_wr(A_STS, 32'h1c);
        bus_wr(A_CTRL, 32'h0);

        // R10 lock, R12 abort
        eng_idx = 0; eng_gap = 3; eng_err_at = -1;
        bus_wr(A_CTRL, (32'd200 << 20) | (32'd3 << 2) | 32'h1);
        repeat (3) @(negedge clk);
        bus_wr(A_CTRL, (32'd5 << 20) | (32'd0 << 2) | 32'h1);
        bus_rd(A_CTRL, d);
        check("R10 length locked", {20'b0, d[31:20]}, 200);
        check("R10 type locked", {30'b0, d[3:2]}, 3);
        check("R10 enable kept", {31'b0, d[0]}, 1);
        bus_wr(A_CTRL, 32'h0);
        repeat (3) @(negedge clk);
        check("R12 abort stops requests", {31'b0, eng_req}, 0);
        bus_rd(A_STS, s);
        check("R12 abort sets no event", s & 32'h1c, 0);
        bus_rd(A_CTRL, d);
        check("R12 enable cleared", {31'b0, d[0]}, 0);

        // R7 error after one chunk
        eng_idx = 0; eng_gap = 0; eng_err_at = 70;
        bus_wr(A_CTRL, (32'd130 << 20) | (32'd3 << 2) | 32'h1);
        wait_irq(3000, ok);
        bus_rd(A_STS, s);
        check("R7 first chunk full", s & 32'h1c, 32'h8);
        bus_wr(A_STS, 32'h8);
        bus_wr(A_CTRL, 32'h3);
        repeat (2) @(negedge clk);
        wait_irq(3000, ok);
        bus_rd(A_STS, s);
        check("R7 error status", s & 32'h1c, 32'h10);
        check("R7 no request after error", {31'b0, eng_req}, 0);
        check_win("R7 window kept", 64, 6, 1);
        bus_wr(A_STS, 32'h1c);
        bus_wr(A_CTRL, 32'h0);
        eng_err_at = -1;

        // R8, R9 mask and clear
        bus_wr(A_IEN, 32'h0);
        eng_idx = 0;
        bus_wr(A_CTRL, (32'd3 << 20) | (32'd3 << 2) | 32'h1);
        repeat (20) @(negedge clk);
        check("R9 masked irq low", {31'b0, irq}, 0);
        bus_wr(A_STS, 32'h0);
        bus_rd(A_STS, s);
        check("R8 zero write keeps status", s, 32'h4);
        bus_wr(A_IEN, 32'h4);
        @(negedge clk);
        check("R9 unmasked irq high", {31'b0, irq}, 1);
        bus_wr(A_STS, 32'h4);
        repeat (2) @(negedge clk);
        bus_rd(A_STS, s);
        check("R8 one write clears", s, 0);
        check("R9 irq drops after clear", {31'b0, irq}, 0);
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_IEN, 32'h1d);

        // R11 hot-plug edge
        @(negedge clk);
        hpd_in = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd(A_STS, s);
        check("R11 hot-plug sets bit 0", s, 32'h1);
        check("R11 hot-plug irq", {31'b0, irq}, 1);
        bus_wr(A_STS, 32'h1);
        repeat (3) @(negedge clk);
        bus_rd(A_STS, s);
        check("R11 level does not re-set", s, 0);

        summary();
    end

endmodule